// File: doc/BRIEF.md
# Flash Command Decoder

This block turns the command bytes a host writes to a flash device into read-path mode changes and job requests for the program/erase sequencer. Each accepted bus write is decoded in one clock. The decoder keeps the read-path selection (array, identify, status or one-time-programmable area). It tracks the two-write sequences: setup then confirm, double entry and double exit of the one-time area, and protection setup then sub-code. It also knows which job is running or suspended, so it can filter the commands allowed in each of those states.

The sequencer receives one-cycle start, suspend and resume strobes together with a job kind, an address and a data word. It reports back with a completion pulse that carries error flags. The decoder composes the 8-bit status byte from its own state and from sticky error bits. While in identify mode it also returns the identification word for the read address presented.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After rst_n or a cycle with rp_n low, rd_sel is 0 (array), status is 80h and no strobe is high. Writes seen while rp_n is low have no effect.
- R2: When ready, FFh sets rd_sel to 0 (array), 90h sets it to 1 (identify) and 70h sets it to 2 (status). Any byte that is not a command leaves rd_sel and status unchanged and raises no strobe.
- R3: When ready, 50h clears status bits 5, 4, 3 and 1 and sets rd_sel to 0.
- R4: 10h or 40h followed by any write raises job_start for one cycle with job_kind 0 (program) and the address and data of the second write. From then on rd_sel is 2 and status bit 7 is 0 until seq_done.
- R5: 20h followed by D0h raises job_start with job_kind 1 (erase) and the address of the confirm write.
- R6: After 20h, a second byte other than D0h starts no job. It sets status bits 5 and 4, pulses cmd_seq_err, sets rd_sel to 2 and leaves the decoder ready.
- R7: While a program or erase job runs, only B0h has an effect. It pulses job_suspend and sets status bit 7 together with bit 2 (program suspended) or bit 6 (erase suspended).
- R8: In program suspend, FFh and 70h change rd_sel and D0h pulses job_resume and returns to busy. Every other byte, erase setup included, is ignored.
- R9: In erase suspend, a program setup sequence starts a program job. Its seq_done returns to erase suspend with bit 6 still set, and D0h then pulses job_resume.
- R10: id_data is 002Ch at rd_addr 0, 4492h at rd_addr 1 when TOP_BOOT=1 (4493h otherwise), and 0000h elsewhere.
- R11: Two consecutive AFh writes set rd_sel to 3. A single AFh followed by another byte cancels the entry. In the one-time area mode a program sequence starts job_kind 3, and two consecutive FFh writes return rd_sel to 0.
- R12: 0Fh followed by any write raises job_start with job_kind 2 (protection) and carries that write's address and sub-code.
- R13: A seq_done during a job ORs seq_flags into the sticky status bits, with bit 3 going to bit 5, bit 2 to bit 4, bit 1 to bit 3 and bit 0 to bit 1. These bits stay set until 50h or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rp_n | input | 1 | Reset/power-down request, active low, sampled on the clock |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Address of the host write |
| wr_data | input | DATA_W | Data of the host write; command code in bits 7:0 |
| rd_addr | input | ADDR_W | Current read address, used for identify data |
| seq_done | input | 1 | Sequencer finished the running job |
| seq_flags | input | 4 | Error flags valid with seq_done: erase, program, supply, lock |
| rd_sel | output | 2 | Read mux select: 0 array, 1 identify, 2 status, 3 one-time area |
| status | output | 8 | Status byte |
| id_data | output | 16 | Identification word for rd_addr |
| job_start | output | 1 | One-cycle job start strobe |
| job_kind | output | 2 | 0 program, 1 erase, 2 protection, 3 one-time area program |
| job_addr | output | ADDR_W | Job address |
| job_data | output | DATA_W | Job data or protection sub-code |
| job_suspend | output | 1 | One-cycle suspend strobe |
| job_resume | output | 1 | One-cycle resume strobe |
| cmd_seq_err | output | 1 | One-cycle pulse on a wrong confirm byte |

## Verification
Every registered result (rd_sel, status, the strobes, job fields and cmd_seq_err) is due in the cycle after the edge that samples wr_en or seq_done. The strobes last exactly that one cycle. id_data is combinational and is due in the same cycle as rd_addr. The bench drives each write on a falling edge and removes it on the next falling edge, then checks the outputs at that second falling edge, which lies inside the strobe cycle. For cmd_seq_err it checks one cycle later as well, to see that the pulse has ended.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int CMD_W = 8;

  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_IDENT = 2'd1, RD_STATUS = 2'd2, RD_OTP = 2'd3} rd_sel_e;
  typedef enum logic [1:0] {JOB_PGM = 2'd0, JOB_ERASE = 2'd1, JOB_PROT = 2'd2, JOB_OTP_PGM = 2'd3} job_kind_e;

  typedef enum logic [3:0] {
    S_READY, S_PGM_SETUP, S_ERS_SETUP, S_PROT_SETUP,
    S_OTP_ARM, S_OTP, S_OTP_EXIT_ARM, S_OTP_PGM_SETUP, S_OTP_PGM_RUN,
    S_PGM_RUN, S_PGM_SUSP, S_ERS_RUN, S_ERS_SUSP, S_ES_PGM_SETUP, S_ES_PGM_RUN
  } dstate_e;

  localparam logic [CMD_W-1:0] OP_ARRAY   = 8'hFF;
  localparam logic [CMD_W-1:0] OP_IDENT   = 8'h90;
  localparam logic [CMD_W-1:0] OP_STATUS  = 8'h70;
  localparam logic [CMD_W-1:0] OP_CLEAR   = 8'h50;
  localparam logic [CMD_W-1:0] OP_PGM_A   = 8'h10;
  localparam logic [CMD_W-1:0] OP_PGM_B   = 8'h40;
  localparam logic [CMD_W-1:0] OP_ERASE   = 8'h20;
  localparam logic [CMD_W-1:0] OP_CONFIRM = 8'hD0;
  localparam logic [CMD_W-1:0] OP_SUSPEND = 8'hB0;
  localparam logic [CMD_W-1:0] OP_PROTECT = 8'h0F;
  localparam logic [CMD_W-1:0] OP_OTP     = 8'hAF;

  function automatic logic is_pgm_setup(input logic [CMD_W-1:0] c);
    return (c == OP_PGM_A) || (c == OP_PGM_B);
  endfunction

  // a job is running in the sequencer
  function automatic logic is_busy(input dstate_e s);
    return (s == S_PGM_RUN) || (s == S_ERS_RUN) || (s == S_ES_PGM_RUN) || (s == S_OTP_PGM_RUN);
  endfunction

  // an erase is held in suspension (also while a nested program runs)
  function automatic logic is_ers_susp(input dstate_e s);
    return (s == S_ERS_SUSP) || (s == S_ES_PGM_SETUP) || (s == S_ES_PGM_RUN);
  endfunction

  // sticky = {erase err, program err, supply err, lock err}
  function automatic logic [7:0] pack_status(input dstate_e s, input logic [3:0] sticky);
    return {~is_busy(s), is_ers_susp(s), sticky[3], sticky[2], sticky[1],
            s == S_PGM_SUSP, sticky[0], 1'b0};
  endfunction

  function automatic logic [15:0] id_word(input logic at_zero, input logic at_one,
                                          input logic [15:0] dev_code);
    if (at_zero) return 16'h002C;
    if (at_one)  return dev_code;
    return 16'h0000;
  endfunction
endpackage

// File: rtl/fcd_id_rom.sv
module fcd_id_rom #(
  parameter int ADDR_W   = 20,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       id_data
);
  import fcd_pkg::*;

  logic [15:0] dev_code;

  generate
    if (TOP_BOOT) begin : g_top
      assign dev_code = 16'h4492;
    end else begin : g_bottom
      assign dev_code = 16'h4493;
    end
  endgenerate

  assign id_data = id_word(rd_addr == '0, rd_addr == ADDR_W'(1), dev_code);
endmodule

// File: rtl/fcd_cmd_fsm.sv
module fcd_cmd_fsm #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rp_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                seq_done,
  output fcd_pkg::dstate_e    state,
  output fcd_pkg::rd_sel_e    rd_sel,
  output logic                job_start,
  output fcd_pkg::job_kind_e  job_kind,
  output logic [ADDR_W-1:0]   job_addr,
  output logic [DATA_W-1:0]   job_data,
  output logic                job_suspend,
  output logic                job_resume,
  output logic                cmd_seq_err,
  output logic                clr_ev,
  output logic                bad_ev
);
  import fcd_pkg::*;

  dstate_e            nxt;
  rd_sel_e            rsel_n;
  job_kind_e          kind_n;
  logic               start_n, susp_n, res_n;
  logic [ADDR_W-1:0]  addr_n;
  logic [DATA_W-1:0]  data_n;
  logic               wr;
  logic [CMD_W-1:0]   code;

  assign wr   = wr_en && rp_n;
  assign code = wr_data[CMD_W-1:0];

  always_comb begin
    nxt = state; rsel_n = rd_sel; kind_n = job_kind;
    addr_n = job_addr; data_n = job_data;
    start_n = 1'b0; susp_n = 1'b0; res_n = 1'b0;
    clr_ev = 1'b0; bad_ev = 1'b0;
    case (state)
      S_READY: if (wr) begin
        if (code == OP_ARRAY)          rsel_n = RD_ARRAY;
        else if (code == OP_IDENT)     rsel_n = RD_IDENT;
        else if (code == OP_STATUS)    rsel_n = RD_STATUS;
        else if (code == OP_CLEAR)     begin clr_ev = 1'b1; rsel_n = RD_ARRAY; end
        else if (is_pgm_setup(code))   nxt = S_PGM_SETUP;
        else if (code == OP_ERASE)     nxt = S_ERS_SETUP;
        else if (code == OP_PROTECT)   nxt = S_PROT_SETUP;
        else if (code == OP_OTP)       nxt = S_OTP_ARM;
      end
      S_PGM_SETUP, S_ES_PGM_SETUP, S_OTP_PGM_SETUP: if (wr) begin
        start_n = 1'b1; addr_n = wr_addr; data_n = wr_data; rsel_n = RD_STATUS;
        kind_n  = (state == S_OTP_PGM_SETUP) ? JOB_OTP_PGM : JOB_PGM;
        nxt     = (state == S_PGM_SETUP) ? S_PGM_RUN :
                  (state == S_ES_PGM_SETUP) ? S_ES_PGM_RUN : S_OTP_PGM_RUN;
      end
      S_ERS_SETUP: if (wr) begin
        rsel_n = RD_STATUS;
        if (code == OP_CONFIRM) begin
          start_n = 1'b1; kind_n = JOB_ERASE; addr_n = wr_addr; data_n = wr_data;
          nxt = S_ERS_RUN;
        end else begin
          bad_ev = 1'b1; nxt = S_READY;
        end
      end
      S_PROT_SETUP: if (wr) begin
        start_n = 1'b1; kind_n = JOB_PROT; addr_n = wr_addr; data_n = wr_data;
        nxt = S_READY;
      end
      S_OTP_ARM: if (wr) begin
        if (code == OP_OTP) begin nxt = S_OTP; rsel_n = RD_OTP; end
        else nxt = S_READY;
      end
      S_OTP: if (wr) begin
        if (code == OP_ARRAY)        nxt = S_OTP_EXIT_ARM;
        else if (is_pgm_setup(code)) nxt = S_OTP_PGM_SETUP;
      end
      S_OTP_EXIT_ARM: if (wr) begin
        if (code == OP_ARRAY) begin nxt = S_READY; rsel_n = RD_ARRAY; end
        else nxt = S_OTP;
      end
      S_OTP_PGM_RUN: if (seq_done) nxt = S_OTP;
      S_ES_PGM_RUN:  if (seq_done) nxt = S_ERS_SUSP;
      S_PGM_RUN, S_ERS_RUN: begin
        if (seq_done) nxt = S_READY;
        else if (wr && code == OP_SUSPEND) begin
          susp_n = 1'b1;
          nxt = (state == S_PGM_RUN) ? S_PGM_SUSP : S_ERS_SUSP;
        end
      end
      S_PGM_SUSP, S_ERS_SUSP: if (wr) begin
        if (code == OP_ARRAY)        rsel_n = RD_ARRAY;
        else if (code == OP_STATUS)  rsel_n = RD_STATUS;
        else if (code == OP_CONFIRM) begin
          res_n = 1'b1; rsel_n = RD_STATUS;
          nxt = (state == S_PGM_SUSP) ? S_PGM_RUN : S_ERS_RUN;
        end else if (state == S_ERS_SUSP && is_pgm_setup(code)) nxt = S_ES_PGM_SETUP;
      end
      default: nxt = S_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_READY; rd_sel <= RD_ARRAY; job_kind <= JOB_PGM;
      job_addr <= '0; job_data <= '0;
      job_start <= 1'b0; job_suspend <= 1'b0; job_resume <= 1'b0; cmd_seq_err <= 1'b0;
    end else if (!rp_n) begin
      state <= S_READY; rd_sel <= RD_ARRAY;
      job_start <= 1'b0; job_suspend <= 1'b0; job_resume <= 1'b0; cmd_seq_err <= 1'b0;
    end else begin
      state <= nxt; rd_sel <= rsel_n; job_kind <= kind_n;
      job_addr <= addr_n; job_data <= data_n;
      job_start <= start_n; job_suspend <= susp_n; job_resume <= res_n;
      cmd_seq_err <= bad_ev;
    end
  end

  // R1: a power-down cycle lands in array read with no strobe
  p_rp_array_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> (rd_sel == RD_ARRAY) && !job_start && !job_suspend && !job_resume);

  // R7: strobes to the sequencer never overlap
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({job_start, job_suspend, job_resume}));

  // R7: a running job ignores every byte except suspend
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_PGM_RUN || state == S_ERS_RUN) && rp_n && !seq_done && wr_en && code != OP_SUSPEND)
    |=> (state == $past(state)) && !job_suspend);

  // R4: a job only starts from a host write
  p_start_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |-> $past(wr_en));

  // R6: a wrong confirm leaves the decoder ready, showing status
  p_bad_to_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_seq_err |-> (state == S_READY) && (rd_sel == RD_STATUS) && !job_start);
endmodule

// File: rtl/fcd_status.sv
module fcd_status (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rp_n,
  input  fcd_pkg::dstate_e state,
  input  logic             clr_ev,
  input  logic             bad_ev,
  input  logic             seq_done,
  input  logic [3:0]       seq_flags,
  output logic [7:0]       status
);
  import fcd_pkg::*;

  logic [3:0] sticky;
  logic [3:0] set_bits;

  assign set_bits = ((seq_done && is_busy(state)) ? seq_flags : 4'b0000)
                  | (bad_ev ? 4'b1100 : 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sticky <= '0;
    else if (!rp_n)   sticky <= '0;
    else if (clr_ev)  sticky <= '0;
    else              sticky <= sticky | set_bits;
  end

  assign status = pack_status(state, sticky);

  // R3: a clear request empties every sticky error bit
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && rp_n) |=> (sticky == 4'b0000));

  // R13: sticky bits only fall through a clear or power-down
  p_sticky_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_n && !clr_ev) |=> ((sticky & $past(sticky)) == $past(sticky)));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              seq_done,
  input  logic [3:0]        seq_flags,
  output logic [1:0]        rd_sel,
  output logic [7:0]        status,
  output logic [15:0]       id_data,
  output logic              job_start,
  output logic [1:0]        job_kind,
  output logic [ADDR_W-1:0] job_addr,
  output logic [DATA_W-1:0] job_data,
  output logic              job_suspend,
  output logic              job_resume,
  output logic              cmd_seq_err
);
  import fcd_pkg::*;

  dstate_e   state;
  rd_sel_e   rsel_q;
  job_kind_e kind_q;
  logic      clr_ev, bad_ev;

  fcd_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .seq_done(seq_done),
    .state(state), .rd_sel(rsel_q),
    .job_start(job_start), .job_kind(kind_q), .job_addr(job_addr), .job_data(job_data),
    .job_suspend(job_suspend), .job_resume(job_resume), .cmd_seq_err(cmd_seq_err),
    .clr_ev(clr_ev), .bad_ev(bad_ev)
  );

  fcd_status u_status (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .state(state),
    .clr_ev(clr_ev), .bad_ev(bad_ev), .seq_done(seq_done), .seq_flags(seq_flags),
    .status(status)
  );

  fcd_id_rom #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_id (
    .rd_addr(rd_addr), .id_data(id_data)
  );

  assign rd_sel   = rsel_q;
  assign job_kind = kind_q;

  // R6: the sequence-error pulse coincides with both error bits set
  p_seq_err_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_seq_err |-> (status[5:4] == 2'b11));

  // R4: while a job is running the read path shows status
  p_busy_shows_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[7]) |-> (rd_sel == 2'd2));
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rp_n = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          seq_done = 1'b0;
  logic [3:0]    seq_flags = '0;
  logic [1:0]    rd_sel;
  logic [7:0]    status;
  logic [15:0]   id_data;
  logic          job_start, job_suspend, job_resume, cmd_seq_err;
  logic [1:0]    job_kind;
  logic [AW-1:0] job_addr;
  logic [DW-1:0] job_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .TOP_BOOT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .seq_done(seq_done), .seq_flags(seq_flags),
    .rd_sel(rd_sel), .status(status), .id_data(id_data), .job_start(job_start),
    .job_kind(job_kind), .job_addr(job_addr), .job_data(job_data),
    .job_suspend(job_suspend), .job_resume(job_resume), .cmd_seq_err(cmd_seq_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] code, input logic [15:8] hi = 8'h00);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = {hi, code};
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic done(input logic [3:0] f);
    @(negedge clk); seq_done = 1'b1; seq_flags = f;
    @(negedge clk); seq_done = 1'b0; seq_flags = '0;
  endtask

  task automatic power_down();
    @(negedge clk); rp_n = 1'b0;
    @(negedge clk); rp_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 rd_sel after reset", rd_sel, 0);
    chk("R1 status after reset", status, 8'h80);
    chk("R1 no strobe after reset", {job_start, job_suspend, job_resume}, 0);
    wr(0, 8'h90);
    wr(0, 8'h20); wr(0, 8'h11);
    @(negedge clk); rp_n = 1'b0; wr_en = 1'b1; wr_data = 16'h0050;
    @(negedge clk); rp_n = 1'b1; wr_en = 1'b0;
    chk("R1 rd_sel after rp_n", rd_sel, 0);
    chk("R1 status after rp_n", status, 8'h80);
  endtask

  task automatic t_read_modes();
    wr(0, 8'h90); chk("R2 identify select", rd_sel, 1);
    wr(0, 8'h70); chk("R2 status select", rd_sel, 2);
    wr(0, 8'hB0); chk("R2 suspend ignored when ready", rd_sel, 2);
    wr(0, 8'hFF); chk("R2 array select", rd_sel, 0);
    wr(0, 8'h33);
    chk("R2 unknown byte rd_sel", rd_sel, 0);
    chk("R2 unknown byte status", status, 8'h80);
    chk("R2 unknown byte no start", job_start, 0);
  endtask

  task automatic t_program();
    wr(0, 8'h10); chk("R4 setup alone starts nothing", job_start, 0);
    wr(20'h12345, 8'hEF, 8'hBE);
    chk("R4 start", job_start, 1);
    chk("R4 kind", job_kind, 0);
    chk("R4 addr", job_addr, 20'h12345);
    chk("R4 data", job_data, 16'hBEEF);
    chk("R4 rd_sel status", rd_sel, 2);
    chk("R4 busy status", status, 8'h00);
    @(negedge clk); chk("R4 start is one cycle", job_start, 0);
    done(4'b0000); chk("R4 ready after done", status, 8'h80);
    wr(0, 8'h40); wr(20'h00ABC, 8'h34, 8'h12);
    chk("R4 alt setup addr", job_addr, 20'h00ABC);
    chk("R4 alt setup data", job_data, 16'h1234);
    done(4'b0000);
  endtask

  task automatic t_erase();
    wr(20'h30000, 8'h20); chk("R5 setup starts nothing", job_start, 0);
    wr(20'h30005, 8'hD0);
    chk("R5 start", job_start, 1);
    chk("R5 kind", job_kind, 1);
    chk("R5 addr", job_addr, 20'h30005);
    chk("R5 busy status", status, 8'h00);
    done(4'b0000); chk("R5 ready after done", status, 8'h80);
  endtask

  task automatic t_bad_confirm_and_clear();
    wr(0, 8'h20); wr(0, 8'hFF);
    chk("R6 no start", job_start, 0);
    chk("R6 err pulse", cmd_seq_err, 1);
    chk("R6 status bits", status, 8'hB0);
    chk("R6 rd_sel status", rd_sel, 2);
    @(negedge clk); chk("R6 err pulse ends", cmd_seq_err, 0);
    wr(0, 8'hD0); chk("R6 decoder ready, D0 alone ignored", job_start, 0);
    wr(0, 8'h50);
    chk("R3 clear status", status, 8'h80);
    chk("R3 clear returns to array", rd_sel, 0);
  endtask

  task automatic t_busy_and_pgm_suspend();
    wr(0, 8'h10); wr(20'h00100, 8'h00);
    wr(0, 8'hFF);
    chk("R7 FF ignored while busy", rd_sel, 2);
    chk("R7 still busy", status, 8'h00);
    wr(0, 8'hD0); chk("R7 D0 ignored while busy", job_resume, 0);
    wr(0, 8'hB0);
    chk("R7 suspend strobe", job_suspend, 1);
    chk("R7 program suspended status", status, 8'h84);
    wr(0, 8'hFF); chk("R8 array read in suspend", rd_sel, 0);
    wr(0, 8'h20); chk("R8 erase setup ignored", status, 8'h84);
    wr(0, 8'h70); chk("R8 status read in suspend", rd_sel, 2);
    wr(0, 8'hD0);
    chk("R8 resume strobe", job_resume, 1);
    chk("R8 resume not a new job", job_start, 0);
    chk("R8 busy again", status, 8'h00);
    done(4'b0000); chk("R8 ready after done", status, 8'h80);
  endtask

  task automatic t_erase_suspend();
    wr(20'h10000, 8'h20); wr(20'h10000, 8'hD0);
    wr(0, 8'hB0);
    chk("R7 erase suspend strobe", job_suspend, 1);
    chk("R7 erase suspended status", status, 8'hC0);
    wr(0, 8'h10); wr(20'h50000, 8'hFF);
    chk("R9 nested program start", job_start, 1);
    chk("R9 nested program kind", job_kind, 0);
    chk("R9 nested program addr", job_addr, 20'h50000);
    chk("R9 nested busy keeps SR6", status, 8'h40);
    done(4'b0000); chk("R9 back to erase suspend", status, 8'hC0);
    wr(0, 8'hD0);
    chk("R9 erase resume strobe", job_resume, 1);
    chk("R9 erase busy", status, 8'h00);
    done(4'b0000); chk("R9 ready after erase", status, 8'h80);
  endtask

  task automatic t_seq_flags();
    wr(0, 8'h40); wr(20'h00200, 8'h00);
    done(4'b0110); chk("R13 program/supply flags", status, 8'h98);
    wr(20'h08000, 8'h20); wr(20'h08000, 8'hD0);
    done(4'b1001); chk("R13 flags accumulate", status, 8'hBA);
    wr(0, 8'h50); chk("R13 cleared by 50h", status, 8'h80);
  endtask

  task automatic t_identify();
    rd_addr = 20'h00000; #1; chk("R10 maker code", id_data, 16'h002C);
    rd_addr = 20'h00001; #1; chk("R10 device code", id_data, 16'h4492);
    rd_addr = 20'h00002; #1; chk("R10 other address", id_data, 16'h0000);
    rd_addr = 20'h10000; #1; chk("R10 high address", id_data, 16'h0000);
  endtask

  task automatic t_otp();
    wr(0, 8'hAF); chk("R11 single entry byte", rd_sel, 0);
    wr(0, 8'h33); wr(0, 8'hAF); chk("R11 cancelled entry", rd_sel, 0);
    wr(0, 8'hAF); chk("R11 otp mode", rd_sel, 3);
    wr(0, 8'hFF); wr(0, 8'h70); chk("R11 broken exit stays", rd_sel, 3);
    wr(0, 8'h40); wr(20'h00022, 8'h5A, 8'h5A);
    chk("R11 otp program start", job_start, 1);
    chk("R11 otp program kind", job_kind, 3);
    chk("R11 otp program busy", status, 8'h00);
    done(4'b0000); chk("R11 otp ready", status, 8'h80);
    wr(0, 8'hFF); chk("R11 one exit byte", rd_sel, 2);
    wr(0, 8'hFF); chk("R11 exit to array", rd_sel, 0);
  endtask

  task automatic t_protect();
    wr(0, 8'h0F); chk("R12 setup alone", job_start, 0);
    wr(20'h48000, 8'hF0);
    chk("R12 start", job_start, 1);
    chk("R12 kind", job_kind, 2);
    chk("R12 addr", job_addr, 20'h48000);
    chk("R12 sub-code", job_data, 16'h00F0);
    chk("R12 stays ready", status, 8'h80);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_modes();
    t_program();
    t_erase();
    t_bad_confirm_and_clear();
    t_busy_and_pgm_suspend();
    t_erase_suspend();
    t_seq_flags();
    t_identify();
    t_otp();
    power_down();
    t_protect();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule